// File: doc/BRIEF.md
# Shift-Clock Timer with Stop-Bit Phase

This block is a down-counting timer that makes the shift clock for the shift registers attached to it and marks the edges of each word. It has two parts. A half-period counter sets how often the shift clock toggles. A bit counter sets how many shift-clock cycles make up one word. Both counters load from a compare value. The low field of the compare value gives the half-period. The high field gives the bit count.

When the last bit of a word ends, the timer raises a one-cycle compare strobe. The attached shifters use this strobe to emit or capture a stop bit. A two-bit stop mode can add a stop-bit phase after each compare, after a disable, or after both. During the phase that follows a disable, the counter keeps decrementing until the next shift-clock rising point. A new enable request is accepted only at that point.

The counters step either on every clock cycle or only on rising edges of an external source clock. The decrement select input picks which.

The controller has four states:
- IDLE: waiting for an enable.
- RUN: shifting a word.
- STOP_CMP: stop bit after a compare, with the timer output still high.
- STOP_DIS: stop bit after a disable, with the timer output low.

The transitions are:
- IDLE→RUN on start.
- RUN→RUN on a compare when there is no stop bit.
- RUN→STOP_CMP on a compare when stop mode bit 0 is set.
- STOP_CMP→RUN at the finishing point.
- RUN or STOP_CMP→STOP_DIS on a halt when stop mode bit 1 is set.
- RUN or STOP_CMP→IDLE on a halt when stop mode bit 1 is clear and start is low.
- RUN or STOP_CMP→RUN on a halt when stop mode bit 1 is clear and start is high.
- STOP_DIS→RUN at the finishing point when start is high.
- STOP_DIS→IDLE at the finishing point when start is low.

Top module: `shift_timer`

## Requirements
- R1: While reset is asserted, and afterwards until a start is seen, tout_o, sclk_o, cmp_o and stop_o are all low.
- R2: In IDLE, a high start_i moves the timer to RUN. In the next cycle tout_o is 1 and sclk_o is 0. Both counters are loaded from cmp_val_i: the low LO_W bits go to the half-period counter and the upper HI_W bits go to the bit counter.
- R3: When dec_sel_i is 0, a tick happens on every clock. When dec_sel_i is 1, a tick happens only in a cycle where src_clk_i is 1 and was 0 in the previous cycle.
- R4: In RUN, a tick with a nonzero half-period counter decrements that counter. A tick with a zero half-period counter reloads it from the current low field and toggles sclk_o. If sclk_o was 1 before the toggle, the bit counter also decrements.
- R5: In RUN, a compare happens on a tick where the half-period counter is 0, the bit counter is 0 and sclk_o is 1. On a compare, cmp_o is 1 for exactly the next cycle, and sclk_o is 0 in that cycle.
- R6: When stop_mode_i bit 0 is 1, a compare enters STOP_CMP. In that state stop_o=1, tout_o=1 and sclk_o=0, while the half-period counter, reloaded at the compare, runs down. On the tick that finds it at 0, both counters reload and the timer returns to RUN.
- R7: When stop_mode_i bit 0 is 0, a compare reloads both counters from cmp_val_i and stays in RUN. A new word then starts with no gap.
- R8: In RUN or STOP_CMP, a high halt_i with stop_mode_i bit 1 clear sends the timer to IDLE, so tout_o is 0 in the next cycle. If start_i is also high in that cycle, the timer reloads and stays in RUN with tout_o=1.
- R9: In RUN or STOP_CMP, a high halt_i with stop_mode_i bit 1 set reloads the counters and enters STOP_DIS, with stop_o=1 and tout_o=0. The half-period counter then runs down. start_i is ignored until the tick that finds the counter at 0. On that tick the timer goes to RUN if start_i is high and to IDLE otherwise.
- R10: The bit counter takes cmp_val_i only at a load (start, compare, halt or the end of a stop phase). A change to the high field in the middle of a word leaves the length of the current word unchanged.
- R11: halt_i has no effect in IDLE or in STOP_DIS. In STOP_DIS the stop phase still ends at the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_val_i | input | LO_W+HI_W | Compare value: half-period in the low field, bits-per-word minus one in the high field |
| dec_sel_i | input | 1 | 0: tick on every clock; 1: tick on rising edges of src_clk_i |
| src_clk_i | input | 1 | External decrement source |
| start_i | input | 1 | Enable condition |
| halt_i | input | 1 | Disable condition |
| stop_mode_i | input | 2 | Bit 0: stop bit on compare; bit 1: stop bit on disable |
| tout_o | output | 1 | Timer output, high while a word is framed |
| sclk_o | output | 1 | Shift clock |
| cmp_o | output | 1 | One-cycle compare strobe |
| stop_o | output | 1 | High during either stop-bit phase |

## Verification
The bench builds the timer with a 4-bit half-period field and a 3-bit bit-count field. With these widths a whole word, its compare strobe and both kinds of stop phase fit into a few dozen cycles. This lets a single run cover back-to-back words, a change to the compare value in the middle of a word, and a halt arriving in each state. The small fields also make short half-periods reachable, including a half-period of 0, which toggles the shift clock on every tick. Running with the external-source decrement mode shows the timer stretching each half-period by the period of the source clock.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_STOP_CMP,
        ST_STOP_DIS
    } st_state_e;

    typedef enum logic [1:0] {
        CC_HOLD,
        CC_LOAD,
        CC_DEC,
        CC_EXPIRE
    } cnt_cmd_e;
endpackage

// File: rtl/st_tick.sv
module st_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_sel_i,
    input  logic src_i,
    output logic tick_o
);
    logic src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_i;
    end

    always_comb begin
        if (dec_sel_i) tick_o = src_i & ~src_q;
        else           tick_o = 1'b1;
    end
endmodule

// File: rtl/st_count.sv
module st_count
    import stmr_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cnt_cmd_e             cmd_i,
    input  logic [LO_W+HI_W-1:0] cmp_i,
    output logic                 lo_zero_o,
    output logic                 hi_zero_o,
    output logic                 sclk_o
);
    localparam int CW = LO_W + HI_W;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            sclk_q <= 1'b0;
        end else begin
            unique case (cmd_i)
                CC_LOAD: begin
                    lo_q   <= cmp_i[LO_W-1:0];
                    hi_q   <= cmp_i[CW-1:LO_W];
                    sclk_q <= 1'b0;
                end
                CC_DEC: begin
                    lo_q <= lo_q - 1'b1;
                end
                CC_EXPIRE: begin
                    lo_q   <= cmp_i[LO_W-1:0];
                    sclk_q <= ~sclk_q;
                    if (sclk_q && (hi_q != '0)) hi_q <= hi_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign lo_zero_o = (lo_q == '0);
    assign hi_zero_o = (hi_q == '0);
    assign sclk_o    = sclk_q;
endmodule

// File: rtl/shift_timer.sv
module shift_timer
    import stmr_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LO_W+HI_W-1:0] cmp_val_i,
    input  logic                 dec_sel_i,
    input  logic                 src_clk_i,
    input  logic                 start_i,
    input  logic                 halt_i,
    input  logic [1:0]           stop_mode_i,
    output logic                 tout_o,
    output logic                 sclk_o,
    output logic                 cmp_o,
    output logic                 stop_o
);
    st_state_e state_q, state_d;
    cnt_cmd_e  cmd;
    logic      tick, lo_zero, hi_zero, cmp_evt, cmp_q;

    st_tick u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_sel_i(dec_sel_i),
        .src_i    (src_clk_i),
        .tick_o   (tick)
    );

    st_count #(.LO_W(LO_W), .HI_W(HI_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .cmp_i    (cmp_val_i),
        .lo_zero_o(lo_zero),
        .hi_zero_o(hi_zero),
        .sclk_o   (sclk_o)
    );

    always_comb begin
        state_d = state_q;
        cmd     = CC_HOLD;
        cmp_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    cmd     = CC_LOAD;
                end
            end
            ST_RUN, ST_STOP_CMP: begin
                if (halt_i) begin
                    cmd = CC_LOAD;
                    if (stop_mode_i[1]) state_d = ST_STOP_DIS;
                    else if (start_i)   state_d = ST_RUN;
                    else                state_d = ST_IDLE;
                end else if (tick) begin
                    if (!lo_zero) begin
                        cmd = CC_DEC;
                    end else if (state_q == ST_STOP_CMP) begin
                        cmd     = CC_LOAD;
                        state_d = ST_RUN;
                    end else if (sclk_o && hi_zero) begin
                        cmp_evt = 1'b1;
                        cmd     = CC_LOAD;
                        state_d = stop_mode_i[0] ? ST_STOP_CMP : ST_RUN;
                    end else begin
                        cmd = CC_EXPIRE;
                    end
                end
            end
            ST_STOP_DIS: begin
                if (tick) begin
                    if (!lo_zero) begin
                        cmd = CC_DEC;
                    end else if (start_i) begin
                        cmd     = CC_LOAD;
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_evt;
    end

    assign cmp_o  = cmp_q;
    assign tout_o = (state_q == ST_RUN) || (state_q == ST_STOP_CMP);
    assign stop_o = (state_q == ST_STOP_CMP) || (state_q == ST_STOP_DIS);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sclk_o && !cmp_o));

    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (tout_o && !sclk_o && !stop_o));

    p_cmp_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> ($past(sclk_o) && !sclk_o));

    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !sclk_o);

    p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_o && halt_i && !stop_mode_i[1] && !start_i) |=> (!tout_o && !stop_o));

    p_halt_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_o && halt_i && stop_mode_i[1]) |=> (stop_o && !tout_o));

    p_dis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_DIS && !(tick && lo_zero)) |=> (stop_o && !tout_o));
endmodule

// File: tb/shift_timer_bench.sv
module shift_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LO_W = 4;
    localparam int HI_W = 3;
    localparam int CW   = LO_W + HI_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cmp_val = '0;
    logic          dsel = 1'b0;
    logic          src = 1'b0;
    logic          start = 1'b0;
    logic          halt = 1'b0;
    logic [1:0]    smode = 2'b00;
    logic          tout, sclk, cmpo, stopo;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    cmp_on = 0;
    bit    src_run = 0;
    int    src_cnt = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_st = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit m_sclk = 0;
    bit m_cmp = 0;
    bit m_srcq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_timer #(.LO_W(LO_W), .HI_W(HI_W)) u_shift_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_val_i  (cmp_val),
        .dec_sel_i  (dsel),
        .src_clk_i  (src),
        .start_i    (start),
        .halt_i     (halt),
        .stop_mode_i(smode),
        .tout_o     (tout),
        .sclk_o     (sclk),
        .cmp_o      (cmpo),
        .stop_o     (stopo)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, got, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit tk, ld, ncmp;
        if (!rst_n) begin
            m_st = 0; m_lo = 0; m_hi = 0; m_sclk = 0; m_cmp = 0; m_srcq = 0;
        end else begin
            tk = dsel ? (src && !m_srcq) : 1'b1;
            m_srcq = src;
            ld = 0;
            ncmp = 0;
            if (m_st == 0) begin
                if (start) begin m_st = 1; ld = 1; end
            end else if (m_st == 3) begin
                if (tk) begin
                    if (m_lo != 0)  m_lo = m_lo - 1;
                    else if (start) begin m_st = 1; ld = 1; end
                    else            m_st = 0;
                end
            end else begin
                if (halt) begin
                    ld = 1;
                    m_st = smode[1] ? 3 : (start ? 1 : 0);
                end else if (tk) begin
                    if (m_lo != 0) m_lo = m_lo - 1;
                    else if (m_st == 2) begin ld = 1; m_st = 1; end
                    else if (m_sclk && m_hi == 0) begin
                        ncmp = 1; ld = 1; m_st = smode[0] ? 2 : 1;
                    end else begin
                        m_lo = int'(cmp_val[LO_W-1:0]);
                        if (m_sclk) m_hi = m_hi - 1;
                        m_sclk = !m_sclk;
                    end
                end
            end
            if (ld) begin
                m_lo = int'(cmp_val[LO_W-1:0]);
                m_hi = int'(cmp_val[CW-1:LO_W]);
                m_sclk = 0;
            end
            m_cmp = ncmp;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "tout", tout, (m_st == 1 || m_st == 2));
            chk(cur_req, "sclk", sclk, m_sclk);
            chk(cur_req, "cmp",  cmpo, m_cmp);
            chk(cur_req, "stop", stopo, (m_st >= 2));
        end
        if (src_run) begin
            src_cnt++;
            if (src_cnt == 2) begin src = ~src; src_cnt = 0; end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        chk("R1", "tout in reset", tout, 1'b0);
        chk("R1", "sclk in reset", sclk, 1'b0);
        chk("R1", "cmp in reset",  cmpo, 1'b0);
        chk("R1", "stop in reset", stopo, 1'b0);
        rst_n = 1'b1;
        cmp_on = 1;
        wait_n(3);

        cur_req = "R2";
        cmp_val = {3'd2, 4'd2};
        start = 1'b1;
        wait_n(1);
        start = 1'b0;
        chk("R2", "tout after start", tout, 1'b1);
        chk("R2", "sclk after start", sclk, 1'b0);
        cur_req = "R4"; wait_n(20);
        cur_req = "R5"; wait_n(20);
        cur_req = "R7"; wait_n(20);

        cur_req = "R6";
        smode = 2'b01;
        wait_n(60);

        cur_req = "R10";
        cmp_val = {3'd0, 4'd1};
        wait_n(40);
        cmp_val = {3'd3, 4'd0};
        wait_n(40);

        cur_req = "R8";
        smode = 2'b00;
        cmp_val = {3'd1, 4'd2};
        halt = 1'b1;
        wait_n(1);
        halt = 1'b0;
        chk("R8", "tout after halt", tout, 1'b0);
        start = 1'b1;
        wait_n(1);
        start = 1'b0;
        wait_n(5);
        halt = 1'b1;
        start = 1'b1;
        wait_n(1);
        halt = 1'b0;
        start = 1'b0;
        chk("R8", "tout on halt with start", tout, 1'b1);
        wait_n(10);

        cur_req = "R9";
        smode = 2'b10;
        cmp_val = {3'd1, 4'd3};
        halt = 1'b1;
        wait_n(1);
        halt = 1'b0;
        chk("R9", "stop after halt", stopo, 1'b1);
        chk("R9", "tout after halt", tout, 1'b0);
        start = 1'b1;
        wait_n(2);
        chk("R9", "start ignored in stop", tout, 1'b0);
        for (int i = 0; i < 20 && !tout; i++) wait_n(1);
        start = 1'b0;
        chk("R9", "restart at finishing point", tout, 1'b1);
        chk("R9", "stop cleared", stopo, 1'b0);
        wait_n(20);

        cur_req = "R11";
        smode = 2'b00;
        halt = 1'b1;
        wait_n(4);
        halt = 1'b0;
        chk("R11", "halt in idle", tout, 1'b0);
        chk("R11", "halt in idle stop", stopo, 1'b0);
        smode = 2'b10;
        start = 1'b1;
        wait_n(1);
        start = 1'b0;
        wait_n(3);
        halt = 1'b1;
        wait_n(3);
        halt = 1'b0;
        chk("R11", "halt in stop phase", stopo, 1'b1);
        wait_n(15);

        cur_req = "R3";
        smode = 2'b01;
        dsel = 1'b1;
        src_run = 1;
        cmp_val = {3'd1, 4'd1};
        start = 1'b1;
        wait_n(1);
        start = 1'b0;
        wait_n(120);

        cmp_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule